// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations so that an address can be translated without a page-table walk. A lookup presents a full virtual address. In the same cycle, the block compares the page number against the tag of every valid entry. On a match it returns a hit and a physical address. That address is built from the stored frame number and the page offset, which passes through unchanged.

When no entry matches, the block records the page number and raises a miss request on the next cycle. An external walker fetches the translation and delivers it on the refill port. The refill is written into the buffer, and the miss request drops once the refill for the recorded page is accepted. Entries carry no process identifier. Software therefore pulses the flush input on every process switch, which invalidates the whole buffer in one cycle.

A refill goes to the entry that already holds its page if there is one. Otherwise it goes to the lowest-numbered invalid entry. When the buffer is full, a round-robin pointer picks the victim, and the pointer steps only when a valid entry of another page is evicted.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, `missReq` is 0, `hit` is 0 for any lookup of an empty buffer, and the replacement pointer is at entry 0.
- R2: A lookup whose page number (address bits above bit 11 with default parameters) matches a valid entry gives `hit`=1 in the same cycle. In that cycle `paOut` = {stored frame, lookupVa[11:0]}.
- R3: A lookup that matches no valid entry gives `hit`=0 in the same cycle. From the next cycle, `missReq`=1 and `missVpn` equals the page number of that lookup.
- R4: `missReq` and `missVpn` hold until a refill is accepted whose page number equals `missVpn`. While `missReq` is 1, every lookup returns `hit`=0. A refill of any other page is written but leaves `missReq` at 1.
- R5: An accepted refill is visible from the next cycle. A lookup of that page then hits and returns the refilled frame.
- R6: While invalid entries remain, a refill of a new page uses the lowest-numbered invalid entry and evicts nothing. Sixteen distinct refills after a flush all remain resident.
- R7: A refill of a new page into a full buffer replaces the entry at the round-robin pointer. The pointer then advances by one and wraps after the last entry.
- R8: A refill whose page already has a valid entry overwrites that entry's frame. It evicts nothing and does not move the replacement pointer.
- R9: `flush`=1 invalidates all entries, so every lookup in the cycles that follow misses. It does not move the replacement pointer.
- R10: When `flush` and `refillValid` are both 1 in the same cycle, the flush takes effect and the refill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVa | input | 32 | Virtual address to translate |
| hit | output | 1 | Translation found (combinational) |
| paOut | output | 32 | Physical address, valid when `hit` is 1, zero otherwise |
| missReq | output | 1 | Page-table walk requested |
| missVpn | output | 20 | Page number that missed |
| refillValid | input | 1 | Refill translation present |
| refillVpn | input | 20 | Page number being refilled |
| refillPfn | input | 20 | Frame number for that page |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its default parameters: 16 entries, a 32-bit virtual address, a 12-bit offset and a 20-bit frame. With 16 entries, a short run can fill the buffer completely and then go past it. That makes the change from invalid-first placement to round-robin eviction observable, along with the exact victim order and the rule that an overwrite leaves the pointer alone. The 12-bit offset lets lookups place values at both ends of the page to show the pass-through. Each predicted hit, miss and frame comes from a reference map held in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic flushAll;  // clear every valid bit
    logic doWrite;   // write the refill translation
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] wrHitVec,
  input  logic               wrEn,
  input  logic               flushNow,
  output logic [IDX_W-1:0]   wrIdx
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] matchIdx;
  logic             anyFree;
  logic             anyMatch;
  logic             evict;

  // Lowest-numbered invalid entry
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  // Entry already holding the refill page (at most one)
  always_comb begin
    matchIdx = '0;
    anyMatch = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wrHitVec[i]) begin
        matchIdx = IDX_W'(i);
        anyMatch = 1'b1;
      end
    end
  end

  always_comb begin
    evict = !anyMatch && !anyFree;
    if (anyMatch)     wrIdx = matchIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (wrEn && !flushNow && evict) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PFN_W-1:0] wrPfn,
  output logic             lookupMatch,
  output logic [PFN_W-1:0] lookupPfn
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   tagArr [ENTRIES];
  logic [PFN_W-1:0]   pfnArr [ENTRIES];
  logic [ENTRIES-1:0] lkHit;
  logic [ENTRIES-1:0] wrHit;
  logic [IDX_W-1:0]   wrIdx;

  // One comparator pair per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lkHit[g] = validQ[g] && (tagArr[g] == lookupVpn);
    assign wrHit[g] = validQ[g] && (tagArr[g] == wrVpn);
  end

  assign lookupMatch = |lkHit;

  // Tags are unique, so an OR of the masked frames selects the one hit
  always_comb begin
    lookupPfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lookupPfn = lookupPfn | (pfnArr[i] & {PFN_W{lkHit[i]}});
    end
  end

  tlb_victim #(
    .ENTRIES(ENTRIES)
  ) uVictim (
    .clk      (clk),
    .rstN     (rstN),
    .validVec (validQ),
    .wrHitVec (wrHit),
    .wrEn     (strobe.doWrite),
    .flushNow (strobe.flushAll),
    .wrIdx    (wrIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.flushAll) begin
      validQ <= '0;
    end else if (strobe.doWrite) begin
      validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite && !strobe.flushAll) begin
      tagArr[wrIdx] <= wrVpn;
      pfnArr[wrIdx] <= wrPfn;
    end
  end

endmodule

// File: rtl/tlb_ctl.sv
module tlb_ctl
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             lookupMatch,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic             flush,
  output tlbStrobe_t       strobe,
  output logic             hitOk,
  output logic             missPending,
  output logic [VPN_W-1:0] missVpnQ
);

  logic accept;

  always_comb begin
    strobe.flushAll = flush;
    strobe.doWrite  = refillValid && !flush;
  end

  assign accept = strobe.doWrite && missPending && (refillVpn == missVpnQ);
  assign hitOk  = lookupValid && lookupMatch && !missPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missPending <= 1'b0;
      missVpnQ    <= '0;
    end else if (!missPending) begin
      if (lookupValid && !lookupMatch) begin
        missPending <= 1'b1;
        missVpnQ    <= lookupVpn;
      end
    end else if (accept) begin
      missPending <= 1'b0;
    end
  end

endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVa,
  output logic             hit,
  output logic [PA_W-1:0]  paOut,
  output logic             missReq,
  output logic [VPN_W-1:0] missVpn,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic             flush
);

  tlbStrobe_t       strobe;
  logic             lookupMatch;
  logic [PFN_W-1:0] lookupPfn;
  logic [VPN_W-1:0] lookupVpn;

  assign lookupVpn = lookupVa[VA_W-1:OFF_W];

  tlb_ctl #(
    .VPN_W(VPN_W)
  ) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .lookupVpn   (lookupVpn),
    .lookupMatch (lookupMatch),
    .refillValid (refillValid),
    .refillVpn   (refillVpn),
    .flush       (flush),
    .strobe      (strobe),
    .hitOk       (hit),
    .missPending (missReq),
    .missVpnQ    (missVpn)
  );

  tlb_dp #(
    .ENTRIES(ENTRIES),
    .VPN_W  (VPN_W),
    .PFN_W  (PFN_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupVpn   (lookupVpn),
    .wrVpn       (refillVpn),
    .wrPfn       (refillPfn),
    .lookupMatch (lookupMatch),
    .lookupPfn   (lookupPfn)
  );

  assign paOut = hit ? {lookupPfn, lookupVa[OFF_W-1:0]} : '0;

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             hit,
  input logic             missReq,
  input logic [VPN_W-1:0] missVpn,
  input logic             refillValid,
  input logic [VPN_W-1:0] refillVpn,
  input logic             flush
);

  logic acceptNow;
  assign acceptNow = refillValid && !flush && (refillVpn == missVpn);

  // R4
  hit_while_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> !hit);

  // R4
  miss_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !acceptNow) |=> missReq);

  // R4
  miss_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && acceptNow) |=> !missReq);

  // R3
  miss_vpn_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !acceptNow) |=> $stable(missVpn));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

endmodule

bind tlb_top tlb_chk #(.VPN_W(VPN_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .hit         (hit),
  .missReq     (missReq),
  .missVpn     (missVpn),
  .refillValid (refillValid),
  .refillVpn   (refillVpn),
  .flush       (flush)
);

// File: tb/sim_tlb_top.sv
module sim_tlb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVa = '0;
  logic        hit;
  logic [31:0] paOut;
  logic        missReq;
  logic [19:0] missVpn;
  logic        refillValid = 1'b0;
  logic [19:0] refillVpn = '0;
  logic [19:0] refillPfn = '0;
  logic        flush = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tlb_top u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
    .hit(hit), .paOut(paOut), .missReq(missReq), .missVpn(missVpn),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .flush(flush)
  );

  // Reference map
  bit        mValid [16];
  bit [19:0] mVpn   [16];
  bit [19:0] mPfn   [16];
  int        mPtr = 0;
  bit        mPending = 1'b0;
  bit [19:0] mMissVpn = '0;

  typedef struct packed {
    logic        isRefill;
    logic [19:0] vpn;
    logic [19:0] pfnOff;
    logic        expHit;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 20'h00010, 20'h0A000, 1'b0},
    '{1'b0, 20'h00010, 20'h00123, 1'b1},
    '{1'b1, 20'h00020, 20'h0B000, 1'b0},
    '{1'b0, 20'h00020, 20'h00FFF, 1'b1},
    '{1'b0, 20'h00030, 20'h00000, 1'b0},
    '{1'b0, 20'h00030, 20'h00800, 1'b1},
    '{1'b1, 20'h00010, 20'h0C000, 1'b0},
    '{1'b0, 20'h00010, 20'h00001, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int findIdx(input bit [19:0] vpn);
    for (int i = 0; i < 16; i++) if (mValid[i] && mVpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic modelWrite(input bit [19:0] vpn, input bit [19:0] pfn);
    int idx = findIdx(vpn);
    if (idx < 0) begin
      for (int i = 15; i >= 0; i--) if (!mValid[i]) idx = i;
      if (idx < 0) begin
        idx = mPtr;
        mPtr = (mPtr + 1) % 16;
      end
    end
    mValid[idx] = 1'b1;
    mVpn[idx] = vpn;
    mPfn[idx] = pfn;
    if (mPending && vpn == mMissVpn) mPending = 1'b0;
  endtask

  task automatic doRefill(input bit [19:0] vpn, input bit [19:0] pfn,
                          input bit withFlush, input string req);
    @(negedge clk);
    refillValid = 1'b1; refillVpn = vpn; refillPfn = pfn; flush = withFlush;
    @(negedge clk);
    refillValid = 1'b0; flush = 1'b0;
    if (withFlush) begin
      for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    end else begin
      modelWrite(vpn, pfn);
    end
    #2;
    chk(missReq == mPending, req, "missReq after refill", 64'(missReq), 64'(mPending));
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
  endtask

  // Lookup with an explicit expectation cross-checked against the map
  task automatic doLookup(input bit [19:0] vpn, input bit [11:0] off,
                          input bit expHit, input string req);
    int idx = findIdx(vpn);
    bit modelHit = (idx >= 0) && !mPending;
    bit wasPending = mPending;
    chk(modelHit == expHit, req, "bench expectation vs map", 64'(modelHit), 64'(expHit));
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = {vpn, off};
    #2;
    chk(hit == expHit, req, "hit", 64'(hit), 64'(expHit));
    if (expHit)
      chk(paOut == {mPfn[idx], off}, req, "paOut", 64'(paOut), 64'({mPfn[idx], off}));
    @(negedge clk);
    lookupValid = 1'b0;
    #2;
    if (!expHit && !wasPending) begin
      mPending = 1'b1; mMissVpn = vpn;
      chk(missReq == 1'b1, req, "missReq raised", 64'(missReq), 64'd1);
      chk(missVpn == vpn, req, "missVpn", 64'(missVpn), 64'(vpn));
    end else begin
      chk(missReq == mPending, req, "missReq level", 64'(missReq), 64'(mPending));
    end
  endtask

  // Lookup that refills any miss with a derived frame
  task automatic lookupFill(input bit [19:0] vpn, input bit [11:0] off,
                            input bit expHit, input string req);
    doLookup(vpn, off, expHit, req);
    if (!expHit) doRefill(vpn, vpn ^ 20'h5A5A5, 1'b0, "R5");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 1'b0; mVpn[i] = '0; mPfn[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1: reset state
    chk(missReq == 1'b0, "R1", "missReq after reset", 64'(missReq), 64'd0);
    chk(hit == 1'b0, "R1", "hit idle", 64'(hit), 64'd0);
    doLookup(20'h00777, 12'h000, 1'b0, "R1");
    doRefill(20'h00777, 20'h00777, 1'b0, "R4");
    doFlush();

    // Table walk: R2 hits, R3 misses, R5 refills, R8 overwrite
    for (int v = 0; v < 8; v++) begin
      if (VECS[v].isRefill)
        doRefill(VECS[v].vpn, VECS[v].pfnOff, 1'b0, "R5");
      else
        lookupFill(VECS[v].vpn, VECS[v].pfnOff[11:0], VECS[v].expHit,
                   VECS[v].expHit ? "R2" : "R3");
    end

    // R6: sixteen refills after flush all stay resident
    doFlush();
    for (int i = 0; i < 16; i++) doRefill(20'h00100 + 20'(i), 20'h80000 + 20'(i), 1'b0, "R6");
    for (int i = 0; i < 16; i++) doLookup(20'h00100 + 20'(i), 12'(i), 1'b1, "R6");

    // R7: full buffer evicts entry 0 (vpn 100) then entry 1 (vpn 101)
    doRefill(20'h00200, 20'h12345, 1'b0, "R7");
    doLookup(20'h00101, 12'h010, 1'b1, "R7");
    lookupFill(20'h00100, 12'h020, 1'b0, "R7");
    doLookup(20'h00101, 12'h030, 1'b0, "R7");
    doRefill(20'h00101, 20'h22222, 1'b0, "R7");
    doLookup(20'h00200, 12'hABC, 1'b1, "R7");

    // R8: overwrite keeps pointer at entry 3 (vpn 103)
    doRefill(20'h00103, 20'h77777, 1'b0, "R8");
    doLookup(20'h00103, 12'h456, 1'b1, "R8");
    doRefill(20'h00300, 20'h33333, 1'b0, "R8");
    doLookup(20'h00104, 12'h001, 1'b1, "R8");
    doLookup(20'h00300, 12'h002, 1'b1, "R8");

    // R4: pending miss blocks hits, other refill does not release it
    doLookup(20'h00500, 12'h000, 1'b0, "R4");
    doLookup(20'h00300, 12'h003, 1'b0, "R4");
    doRefill(20'h00501, 20'h05010, 1'b0, "R4");
    chk(missVpn == 20'h00500, "R4", "missVpn held", 64'(missVpn), 64'h500);
    doRefill(20'h00500, 20'h05000, 1'b0, "R4");
    doLookup(20'h00501, 12'h004, 1'b1, "R4");

    // R9: flush empties, pointer unchanged
    doFlush();
    lookupFill(20'h00300, 12'h005, 1'b0, "R9");
    lookupFill(20'h00501, 12'h006, 1'b0, "R9");

    // R10: flush and refill together drops the refill
    doRefill(20'h00400, 20'h04000, 1'b1, "R10");
    lookupFill(20'h00400, 12'h007, 1'b0, "R10");
    doLookup(20'h00400, 12'h008, 1'b1, "R10");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule